// File: doc/BRIEF.md
# Pipeline Result Forwarding Unit

This block is the bypass network of a five-stage integer pipeline. It compares the destination register of the instruction in EX/MEM, and of the one in MEM/WB, with the source registers of the instruction in ID/EX. It also compares the MEM/WB destination with the store-data source of the instruction in EX/MEM. From these comparisons it selects the operand for each consumer:

- the two ALU inputs;
- the store data that travels with an ID/EX instruction;
- the data-memory write data of a store in EX/MEM;
- the branch zero test.

The block is purely combinational. It takes the register fields, the instruction class and the candidate values of every stage. It returns the selected values together with their mux selects, so that the surrounding pipeline can use both.

Stalling on load-use dependences is handled outside this block. The register file is also outside it.

Instruction class encoding, on every `*_kind_i` input:

| Code | Class |
|------|-------|
| 0 | no-op |
| 1 | register-register ALU |
| 2 | register-immediate ALU |
| 3 | load |
| 4 | store |
| 5 | branch |
| 6, 7 | treated as no-op |

Select encoding, on every `sel_*_o` output:

| Code | Source |
|------|--------|
| 0 | register-file or carried value |
| 1 | immediate |
| 2 | EX/MEM ALU result |
| 3 | MEM/WB ALU result |
| 4 | MEM/WB loaded data |

Top module: `fwd_unit`

## Requirements
- R1: A producer's destination is its rd field for class 1, and its rt field for classes 2 and 3. Classes 0, 4, 5, 6 and 7 write no register and never supply a forwarded value.
- R2: A source register numbered 0 never matches a producer, even one whose destination is 0; its select is 0 and it takes the register-file value.
- R3: An ID/EX source that matches the destination of an ALU-class (1 or 2) instruction in EX/MEM gets the EX/MEM ALU result (select 2). This holds even when MEM/WB matches the same register.
- R4: An ID/EX source that matches only the MEM/WB destination gets the MEM/WB loaded data (select 4) when MEM/WB is a load, and the MEM/WB ALU result (select 3) otherwise.
- R5: An ID/EX source with no qualifying match gets its register-file value (select 0).
- R6: ALU input B uses the forwarded rt operand only for a class-1 instruction in ID/EX. For every other class it takes the immediate (select 1).
- R7: ALU input A always uses the forwarded rs operand. The ID/EX store-data output always uses the forwarded rt operand.
- R8: For a store (class 4) in EX/MEM, the memory write data is replaced by the MEM/WB value (select 3 or 4) when the MEM/WB destination equals the EX/MEM rt field. Otherwise, and for any other EX/MEM class, the carried rt value passes through with select 0.
- R9: The zero flag is 1 exactly when ID/EX holds a branch (class 5) and the forwarded rs operand equals zero.
- R10: A load in EX/MEM is never a forwarding source for ID/EX (select 2 never appears then), since its data does not yet exist.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| idex_kind_i | input | 3 | Class of the ID/EX instruction |
| idex_rs_i | input | RAW | rs field in ID/EX |
| idex_rt_i | input | RAW | rt field in ID/EX |
| idex_rs_val_i | input | XLEN | Register-file value read for rs |
| idex_rt_val_i | input | XLEN | Register-file value read for rt |
| idex_imm_i | input | XLEN | Sign-extended immediate in ID/EX |
| exmem_kind_i | input | 3 | Class of the EX/MEM instruction |
| exmem_rt_i | input | RAW | rt field in EX/MEM |
| exmem_rd_i | input | RAW | rd field in EX/MEM |
| exmem_alu_i | input | XLEN | ALU result held in EX/MEM |
| exmem_rt_val_i | input | XLEN | Store data carried in EX/MEM |
| memwb_kind_i | input | 3 | Class of the MEM/WB instruction |
| memwb_rt_i | input | RAW | rt field in MEM/WB |
| memwb_rd_i | input | RAW | rd field in MEM/WB |
| memwb_alu_i | input | XLEN | ALU result held in MEM/WB |
| memwb_load_i | input | XLEN | Loaded data held in MEM/WB |
| alu_a_o | output | XLEN | ALU input A |
| sel_a_o | output | 3 | Select used for A |
| alu_b_o | output | XLEN | ALU input B |
| sel_b_o | output | 3 | Select used for B |
| store_data_o | output | XLEN | Store data passed on from ID/EX |
| sel_sd_o | output | 3 | Select used for the store data |
| mem_wdata_o | output | XLEN | Data-memory write data for the EX/MEM store |
| sel_mw_o | output | 3 | Select used for the write data |
| zero_o | output | 1 | Branch zero-test result |

## Verification
The directed cases each isolate one bypass path:

- A back-to-back ALU dependence shows the EX/MEM path.
- A distance-two dependence shows the MEM/WB ALU path.
- A load followed two slots later by a dependent instruction shows the loaded-data path.
- A case where both stages match shows the newer-result priority.
- A load in EX/MEM that matches a source confirms that this path is refused.
- Producers that target register 0, store-data forwarding from a load, and a branch whose operand becomes zero only through forwarding cover the remaining corners.

Random vectors then draw register numbers from a small range, so that single, double and absent matches all occur often. They also mix every class code in every stage, which separates the rd-versus-rt destination choice and the immediate-versus-register choice for B.

// File: rtl/fwd_pkg.sv
// Shared encodings for the forwarding unit: instruction classes and operand selects.
package fwd_pkg;
    typedef enum logic [2:0] {
        K_NOP    = 3'd0,
        K_RR     = 3'd1,
        K_RI     = 3'd2,
        K_LOAD   = 3'd3,
        K_STORE  = 3'd4,
        K_BRANCH = 3'd5
    } kind_e;

    typedef enum logic [2:0] {
        SEL_REG     = 3'd0,
        SEL_IMM     = 3'd1,
        SEL_EXMEM   = 3'd2,
        SEL_WB_ALU  = 3'd3,
        SEL_WB_LOAD = 3'd4
    } sel_e;
endpackage

// File: rtl/fwd_dest_decode.sv
// Derives whether a producing stage writes a register, what kind of value it
// writes and which register it targets.
// Assumes: the class code follows fwd_pkg::kind_e; unknown codes act as no-ops.
module fwd_dest_decode #(
    parameter int RAW = 5
) (
    input  logic [2:0]     kind_i,
    input  logic [RAW-1:0] rt_i,
    input  logic [RAW-1:0] rd_i,
    output logic           wr_o,
    output logic           alu_o,
    output logic           load_o,
    output logic [RAW-1:0] dst_o
);
    import fwd_pkg::*;

    // Class decode: destination field choice and producer type.
    always_comb begin
        wr_o   = 1'b0;
        alu_o  = 1'b0;
        load_o = 1'b0;
        dst_o  = '0;
        case (kind_i)
            K_RR: begin
                wr_o  = 1'b1;
                alu_o = 1'b1;
                dst_o = rd_i;
            end
            K_RI: begin
                wr_o  = 1'b1;
                alu_o = 1'b1;
                dst_o = rt_i;
            end
            K_LOAD: begin
                wr_o   = 1'b1;
                load_o = 1'b1;
                dst_o  = rt_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fwd_src_pick.sv
// Chooses the forwarding source for one consumer register.
// EX/MEM ALU results outrank MEM/WB. Register 0 never matches.
// Assumes: load-use hazards on EX/MEM are stalled elsewhere.
module fwd_src_pick #(
    parameter int RAW = 5
) (
    input  logic [RAW-1:0] src_i,
    input  logic           exm_ok_i,
    input  logic           ex_alu_i,
    input  logic [RAW-1:0] ex_dst_i,
    input  logic           wb_wr_i,
    input  logic           wb_load_i,
    input  logic [RAW-1:0] wb_dst_i,
    output logic [2:0]     sel_o
);
    import fwd_pkg::*;

    logic src_nz;
    logic ex_hit;
    logic wb_hit;

    // Match detection against each producing stage.
    always_comb begin
        src_nz = |src_i;
        ex_hit = exm_ok_i && ex_alu_i && src_nz && (ex_dst_i == src_i);
        wb_hit = wb_wr_i && src_nz && (wb_dst_i == src_i);
    end

    // Priority: newest producer first, then older, else the register file.
    always_comb begin
        if (ex_hit)
            sel_o = SEL_EXMEM;
        else if (wb_hit)
            sel_o = wb_load_i ? SEL_WB_LOAD : SEL_WB_ALU;
        else
            sel_o = SEL_REG;
    end
endmodule

// File: rtl/fwd_operand_mux.sv
// Five-way operand mux driven by an fwd_pkg::sel_e code.
// Assumes: unused codes fall back to the register value.
module fwd_operand_mux #(
    parameter int XLEN = 32
) (
    input  logic [2:0]      sel_i,
    input  logic [XLEN-1:0] reg_i,
    input  logic [XLEN-1:0] imm_i,
    input  logic [XLEN-1:0] exmem_i,
    input  logic [XLEN-1:0] wb_alu_i,
    input  logic [XLEN-1:0] wb_load_i,
    output logic [XLEN-1:0] val_o
);
    import fwd_pkg::*;

    // Operand selection.
    always_comb begin
        case (sel_i)
            SEL_IMM:     val_o = imm_i;
            SEL_EXMEM:   val_o = exmem_i;
            SEL_WB_ALU:  val_o = wb_alu_i;
            SEL_WB_LOAD: val_o = wb_load_i;
            default:     val_o = reg_i;
        endcase
    end
endmodule

// File: rtl/fwd_unit.sv
// Forwarding unit of a five-stage integer pipeline.
// It feeds ALU A and B, the ID/EX store data, the EX/MEM memory write data
// and the branch zero test.
// Assumes: purely combinational; stalls and register file live elsewhere.
module fwd_unit #(
    parameter int XLEN = 32,
    parameter int RAW  = 5
) (
    input  logic [2:0]      idex_kind_i,
    input  logic [RAW-1:0]  idex_rs_i,
    input  logic [RAW-1:0]  idex_rt_i,
    input  logic [XLEN-1:0] idex_rs_val_i,
    input  logic [XLEN-1:0] idex_rt_val_i,
    input  logic [XLEN-1:0] idex_imm_i,
    input  logic [2:0]      exmem_kind_i,
    input  logic [RAW-1:0]  exmem_rt_i,
    input  logic [RAW-1:0]  exmem_rd_i,
    input  logic [XLEN-1:0] exmem_alu_i,
    input  logic [XLEN-1:0] exmem_rt_val_i,
    input  logic [2:0]      memwb_kind_i,
    input  logic [RAW-1:0]  memwb_rt_i,
    input  logic [RAW-1:0]  memwb_rd_i,
    input  logic [XLEN-1:0] memwb_alu_i,
    input  logic [XLEN-1:0] memwb_load_i,
    output logic [XLEN-1:0] alu_a_o,
    output logic [2:0]      sel_a_o,
    output logic [XLEN-1:0] alu_b_o,
    output logic [2:0]      sel_b_o,
    output logic [XLEN-1:0] store_data_o,
    output logic [2:0]      sel_sd_o,
    output logic [XLEN-1:0] mem_wdata_o,
    output logic [2:0]      sel_mw_o,
    output logic            zero_o
);
    import fwd_pkg::*;

    localparam int NPROD = 2;  // EX/MEM, MEM/WB
    localparam int NCONS = 3;  // ID/EX rs, ID/EX rt, EX/MEM rt
    localparam int NMUX  = 4;  // A, B, store data, write data

    logic [2:0]     p_kind [NPROD];
    logic [RAW-1:0] p_rt   [NPROD];
    logic [RAW-1:0] p_rd   [NPROD];
    logic           p_wr   [NPROD];
    logic           p_alu  [NPROD];
    logic           p_load [NPROD];
    logic [RAW-1:0] p_dst  [NPROD];

    logic [RAW-1:0] c_src  [NCONS];
    logic           c_exm  [NCONS];
    logic [2:0]     c_sel  [NCONS];

    logic [2:0]      m_sel [NMUX];
    logic [XLEN-1:0] m_reg [NMUX];
    logic [XLEN-1:0] m_out [NMUX];

    logic is_rr;
    logic ex_store;

    // Gather producer fields into arrays.
    always_comb begin
        p_kind[0] = exmem_kind_i;
        p_rt[0]   = exmem_rt_i;
        p_rd[0]   = exmem_rd_i;
        p_kind[1] = memwb_kind_i;
        p_rt[1]   = memwb_rt_i;
        p_rd[1]   = memwb_rd_i;
    end

    generate
        for (genvar gp = 0; gp < NPROD; gp++) begin : g_prod
            fwd_dest_decode #(.RAW(RAW)) u_dec (
                .kind_i (p_kind[gp]),
                .rt_i   (p_rt[gp]),
                .rd_i   (p_rd[gp]),
                .wr_o   (p_wr[gp]),
                .alu_o  (p_alu[gp]),
                .load_o (p_load[gp]),
                .dst_o  (p_dst[gp])
            );
        end
    endgenerate

    // Consumer sources; EX/MEM cannot feed its own store data.
    always_comb begin
        c_src[0] = idex_rs_i;
        c_exm[0] = 1'b1;
        c_src[1] = idex_rt_i;
        c_exm[1] = 1'b1;
        c_src[2] = exmem_rt_i;
        c_exm[2] = 1'b0;
    end

    generate
        for (genvar gc = 0; gc < NCONS; gc++) begin : g_cons
            fwd_src_pick #(.RAW(RAW)) u_pick (
                .src_i     (c_src[gc]),
                .exm_ok_i  (c_exm[gc]),
                .ex_alu_i  (p_alu[0]),
                .ex_dst_i  (p_dst[0]),
                .wb_wr_i   (p_wr[1]),
                .wb_load_i (p_load[1]),
                .wb_dst_i  (p_dst[1]),
                .sel_o     (c_sel[gc])
            );
        end
    endgenerate

    // Per-consumer select shaping: immediate for B, store-only write data.
    always_comb begin
        is_rr    = (idex_kind_i == K_RR);
        ex_store = (exmem_kind_i == K_STORE);
        m_sel[0] = c_sel[0];
        m_sel[1] = is_rr ? c_sel[1] : SEL_IMM;
        m_sel[2] = c_sel[1];
        m_sel[3] = ex_store ? c_sel[2] : SEL_REG;
        m_reg[0] = idex_rs_val_i;
        m_reg[1] = idex_rt_val_i;
        m_reg[2] = idex_rt_val_i;
        m_reg[3] = exmem_rt_val_i;
    end

    generate
        for (genvar gm = 0; gm < NMUX; gm++) begin : g_mux
            fwd_operand_mux #(.XLEN(XLEN)) u_mux (
                .sel_i     (m_sel[gm]),
                .reg_i     (m_reg[gm]),
                .imm_i     (idex_imm_i),
                .exmem_i   (exmem_alu_i),
                .wb_alu_i  (memwb_alu_i),
                .wb_load_i (memwb_load_i),
                .val_o     (m_out[gm])
            );
        end
    endgenerate

    // Output assignment and branch zero test on the forwarded rs.
    always_comb begin
        alu_a_o      = m_out[0];
        sel_a_o      = m_sel[0];
        alu_b_o      = m_out[1];
        sel_b_o      = m_sel[1];
        store_data_o = m_out[2];
        sel_sd_o     = m_sel[2];
        mem_wdata_o  = m_out[3];
        sel_mw_o     = m_sel[3];
        zero_o       = (idex_kind_i == K_BRANCH) && (m_out[0] == '0);
    end
endmodule

// File: rtl/fwd_unit_chk.sv
// Checker for fwd_unit: immediate assertions relating selects, values and
// stage fields. Attached through bind below.
// Assumes: combinational target, so checks are evaluated whenever inputs settle.
module fwd_unit_chk #(
    parameter int XLEN = 32,
    parameter int RAW  = 5
) (
    input logic [2:0]      idex_kind_i,
    input logic [RAW-1:0]  idex_rs_i,
    input logic [XLEN-1:0] idex_imm_i,
    input logic [2:0]      exmem_kind_i,
    input logic [XLEN-1:0] exmem_alu_i,
    input logic [XLEN-1:0] exmem_rt_val_i,
    input logic [XLEN-1:0] alu_a_o,
    input logic [2:0]      sel_a_o,
    input logic [XLEN-1:0] alu_b_o,
    input logic [2:0]      sel_b_o,
    input logic [XLEN-1:0] mem_wdata_o,
    input logic [2:0]      sel_mw_o,
    input logic            zero_o
);
    // Property checks over the forwarding outputs.
    always_comb begin
        a_r2_zero_reg_no_fwd:
            assert (idex_rs_i != '0 || sel_a_o == 3'd0)
            else $error("R2 violated");
        a_r3_exmem_value:
            assert (sel_a_o != 3'd2 || alu_a_o == exmem_alu_i)
            else $error("R3 violated");
        a_r6_imm_for_non_rr:
            assert (idex_kind_i == 3'd1 || (sel_b_o == 3'd1 && alu_b_o == idex_imm_i))
            else $error("R6 violated");
        a_r8_non_store_passes:
            assert (exmem_kind_i == 3'd4 || (sel_mw_o == 3'd0 && mem_wdata_o == exmem_rt_val_i))
            else $error("R8 violated");
        a_r9_zero_only_branch:
            assert (!zero_o || (idex_kind_i == 3'd5 && alu_a_o == '0))
            else $error("R9 violated");
        a_r10_no_load_source:
            assert (exmem_kind_i != 3'd3 || sel_a_o != 3'd2)
            else $error("R10 violated");
    end
endmodule

bind fwd_unit fwd_unit_chk #(.XLEN(XLEN), .RAW(RAW)) u_chk (.*);

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;
    localparam int XLEN = 32;
    localparam int RAW  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [2:0]      idex_kind, exmem_kind, memwb_kind;
    logic [RAW-1:0]  idex_rs, idex_rt, exmem_rt, exmem_rd, memwb_rt, memwb_rd;
    logic [XLEN-1:0] idex_rs_val, idex_rt_val, idex_imm;
    logic [XLEN-1:0] exmem_alu, exmem_rt_val, memwb_alu, memwb_load;
    logic [XLEN-1:0] alu_a, alu_b, store_data, mem_wdata;
    logic [2:0]      sel_a, sel_b, sel_sd, sel_mw;
    logic            zero;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    fwd_unit #(.XLEN(XLEN), .RAW(RAW)) u_dut (
        .idex_kind_i(idex_kind), .idex_rs_i(idex_rs), .idex_rt_i(idex_rt),
        .idex_rs_val_i(idex_rs_val), .idex_rt_val_i(idex_rt_val), .idex_imm_i(idex_imm),
        .exmem_kind_i(exmem_kind), .exmem_rt_i(exmem_rt), .exmem_rd_i(exmem_rd),
        .exmem_alu_i(exmem_alu), .exmem_rt_val_i(exmem_rt_val),
        .memwb_kind_i(memwb_kind), .memwb_rt_i(memwb_rt), .memwb_rd_i(memwb_rd),
        .memwb_alu_i(memwb_alu), .memwb_load_i(memwb_load),
        .alu_a_o(alu_a), .sel_a_o(sel_a), .alu_b_o(alu_b), .sel_b_o(sel_b),
        .store_data_o(store_data), .sel_sd_o(sel_sd),
        .mem_wdata_o(mem_wdata), .sel_mw_o(sel_mw), .zero_o(zero)
    );

    // R1: destination by class; returns {writes, is_load, alu, dst}
    function automatic logic [RAW+2:0] dest_of(logic [2:0] k, logic [RAW-1:0] rt, logic [RAW-1:0] rd);
        case (k)
            3'd1:    return {3'b101, rd};
            3'd2:    return {3'b101, rt};
            3'd3:    return {3'b110, rt};
            default: return '0;
        endcase
    endfunction

    function automatic logic [2:0] exp_pick(logic [RAW-1:0] src, bit exm_ok);
        logic [RAW+2:0] e, w;
        e = dest_of(exmem_kind, exmem_rt, exmem_rd);
        w = dest_of(memwb_kind, memwb_rt, memwb_rd);
        if (src == '0) return 3'd0;
        if (exm_ok && e[RAW] && e[RAW-1:0] == src) return 3'd2;
        if (w[RAW+2] && w[RAW-1:0] == src) return w[RAW+1] ? 3'd4 : 3'd3;
        return 3'd0;
    endfunction

    function automatic logic [XLEN-1:0] exp_val(logic [2:0] s, logic [XLEN-1:0] r);
        case (s)
            3'd1:    return idex_imm;
            3'd2:    return exmem_alu;
            3'd3:    return memwb_alu;
            3'd4:    return memwb_load;
            default: return r;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] s);
        case (s)
            3'd2:    return "R3";
            3'd3:    return "R4";
            3'd4:    return "R4";
            3'd1:    return "R6";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(string tag, logic [XLEN+2:0] act, logic [XLEN+2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare every output with the bench model (R7 for A and store data).
    task automatic check_all(string extra);
        logic [2:0] ea, eb, esd, emw;
        logic       ez;
        ea  = exp_pick(idex_rs, 1'b1);
        esd = exp_pick(idex_rt, 1'b1);
        eb  = (idex_kind == 3'd1) ? esd : 3'd1;
        emw = (exmem_kind == 3'd4) ? exp_pick(exmem_rt, 1'b0) : 3'd0;
        ez  = (idex_kind == 3'd5) && (exp_val(ea, idex_rs_val) == '0);
        chk({extra, " R7 A ", tag_of(ea)}, {sel_a, alu_a}, {ea, exp_val(ea, idex_rs_val)});
        chk({extra, " R6 B ", tag_of(eb)}, {sel_b, alu_b}, {eb, exp_val(eb, idex_rt_val)});
        chk({extra, " R7 SD ", tag_of(esd)}, {sel_sd, store_data}, {esd, exp_val(esd, idex_rt_val)});
        chk({extra, " R8 MW"}, {sel_mw, mem_wdata}, {emw, exp_val(emw, exmem_rt_val)});
        chk({extra, " R9 Z"}, {{(XLEN+2){1'b0}}, zero}, {{(XLEN+2){1'b0}}, ez});
    endtask

    task automatic set_idle();
        {idex_kind, exmem_kind, memwb_kind} = '0;
        {idex_rs, idex_rt, exmem_rt, exmem_rd, memwb_rt, memwb_rd} = '0;
        idex_rs_val = 32'h11; idex_rt_val = 32'h22; idex_imm = 32'h33;
        exmem_alu = 32'h44; exmem_rt_val = 32'h55; memwb_alu = 32'h66; memwb_load = 32'h77;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    initial begin
        void'($urandom(32'd20240517));
        set_idle();
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        settle();
        // Idle: register values, B takes immediate (R5, R6)
        chk("R5 idle selA", {32'd0, sel_a}, {32'd0, 3'd0});
        chk("R6 idle selB", {32'd0, sel_b}, {32'd0, 3'd1});
        check_all("idle");

        // Back-to-back ALU dependence, RR producer uses rd (R1, R3)
        set_idle(); exmem_kind = 3'd1; exmem_rd = 5'd3; exmem_rt = 5'd9;
        idex_kind = 3'd1; idex_rs = 5'd3; idex_rt = 5'd3; settle();
        chk("R3 b2b A", alu_a, 32'h44);
        chk("R1 b2b rd used B", alu_b, 32'h44);
        check_all("b2b");

        // RR producer rt must not match (R1)
        set_idle(); exmem_kind = 3'd1; exmem_rd = 5'd6; exmem_rt = 5'd3;
        idex_kind = 3'd1; idex_rs = 5'd3; settle();
        chk("R1 rr rt ignored", {29'd0, sel_a}, {29'd0, 3'd0});

        // Distance-two from immediate op (R4)
        set_idle(); memwb_kind = 3'd2; memwb_rt = 5'd4; idex_kind = 3'd2; idex_rs = 5'd4; settle();
        chk("R4 dist2 alu", {sel_a, alu_a}, {3'd3, 32'h66});
        check_all("dist2");

        // Distance-two from load (R4)
        set_idle(); memwb_kind = 3'd3; memwb_rt = 5'd7; idex_kind = 3'd1; idex_rt = 5'd7; settle();
        chk("R4 dist2 load B", {sel_b, alu_b}, {3'd4, 32'h77});

        // Both match: newer wins (R3)
        set_idle(); exmem_kind = 3'd2; exmem_rt = 5'd2; memwb_kind = 3'd1; memwb_rd = 5'd2;
        idex_kind = 3'd1; idex_rs = 5'd2; settle();
        chk("R3 priority", {sel_a, alu_a}, {3'd2, 32'h44});

        // Load in EX/MEM is not a source (R10)
        set_idle(); exmem_kind = 3'd3; exmem_rt = 5'd5; idex_kind = 3'd1; idex_rs = 5'd5; settle();
        chk("R10 exmem load", {29'd0, sel_a}, {29'd0, 3'd0});

        // Load-to-store write data (R8)
        set_idle(); exmem_kind = 3'd4; exmem_rt = 5'd5; memwb_kind = 3'd3; memwb_rt = 5'd5; settle();
        chk("R8 load->store", {sel_mw, mem_wdata}, {3'd4, 32'h77});
        exmem_kind = 3'd1; settle();
        chk("R8 non-store pass", {sel_mw, mem_wdata}, {3'd0, 32'h55});

        // Writes to register 0 (R2)
        set_idle(); exmem_kind = 3'd1; exmem_rd = 5'd0; memwb_kind = 3'd3; memwb_rt = 5'd0;
        idex_kind = 3'd1; idex_rs = 5'd0; idex_rt = 5'd0; settle();
        chk("R2 r0 A", {sel_a, alu_a}, {3'd0, 32'h11});
        chk("R2 r0 B", {sel_b, alu_b}, {3'd0, 32'h22});

        // Branch zero via forwarding (R9)
        set_idle(); idex_rs_val = 32'h5; exmem_kind = 3'd2; exmem_rt = 5'd8; exmem_alu = 32'h0;
        idex_kind = 3'd5; idex_rs = 5'd8; settle();
        chk("R9 zero fwd", {32'd0, zero}, {32'd0, 1'b1});
        idex_kind = 3'd1; settle();
        chk("R9 non-branch", {32'd0, zero}, {32'd0, 1'b0});

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            idex_kind  = 3'($urandom_range(7));
            exmem_kind = 3'($urandom_range(7));
            memwb_kind = 3'($urandom_range(7));
            idex_rs  = 5'($urandom_range(3)); idex_rt  = 5'($urandom_range(3));
            exmem_rt = 5'($urandom_range(3)); exmem_rd = 5'($urandom_range(3));
            memwb_rt = 5'($urandom_range(3)); memwb_rd = 5'($urandom_range(3));
            idex_rs_val  = ($urandom_range(3) == 0) ? 32'd0 : $urandom;
            idex_rt_val  = $urandom;
            idex_imm     = $urandom;
            exmem_alu    = ($urandom_range(3) == 0) ? 32'd0 : $urandom;
            exmem_rt_val = $urandom;
            memwb_alu    = ($urandom_range(3) == 0) ? 32'd0 : $urandom;
            memwb_load   = ($urandom_range(3) == 0) ? 32'd0 : $urandom;
            #1;
            check_all("rand");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R5 actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule